// File: doc/BRIEF.md
# Smart-Card Half-Duplex UART with Parity-Error Handshake

This block is an asynchronous serial transceiver for a single-wire smart-card link. Its transmitter and receiver share one open-drain style line: the block drives two active-low outputs (one from the transmitter, one for error signalling) and observes the resolved line on one input. The line idles high and is treated as a wired-AND, so every device on it sees the sum of both directions.

The transmitter sends frames of one start bit, eight data bits with the least significant first, an even parity bit and one stop bit. It listens to the line in the middle of its own stop bit. A receiver that found bad parity holds the line low there, and the transmitter records that level so an interrupt handler can tell accepted from rejected frames. The receiver checks parity on each incoming frame. On a mismatch it pulls the line low for the stop-bit slot to ask for a repeat. Software writes bytes through a single-entry holding buffer and reads received bytes through a parallel port. Interrupt requests stay raised until software acknowledges them.

Top module: `smartcard_uart`

## Requirements
- R1: After reset both line drives are high, tx_buf_empty, tx_shift_empty and tx_ack_level are 1, and rx_done, rx_parity_err, tx_irq and rx_irq are 0.
- R2: A transmitted frame is a low start bit, eight data bits least significant first, a parity bit that makes the count of ones in data plus parity even, and a high stop bit. Every bit lasts 16 × (baud_div + 1) clock cycles.
- R3: tx_buf_empty is 0 in the cycle after a write. It returns to 1 on the edge where the byte moves into the shift register, and the start bit begins on that same edge.
- R4: tx_shift_empty is 0 from the start bit up to the mid-stop sample and 1 afterwards. tx_irq rises only when tx_shift_empty rises, and it stays high until tx_irq_ack.
- R5: tx_ack_level takes the line level seen at the middle of the transmitted stop bit: 1 means accepted, 0 means rejected. It changes at no other time.
- R6: The receiver starts on a falling line edge and confirms the start bit half a bit later. A low pulse that has ended by then is dropped, and the receiver returns to idle.
- R7: The receiver samples each bit at mid-bit. At the middle of the stop bit it sets rx_done and rx_irq, presents the byte on rd_data, and sets rx_parity_err to 1 if data plus parity hold an odd count of ones.
- R8: On a parity error, err_line_drv goes low for one bit time, starting half a bit after the parity sample, which is the stop-bit slot. With good parity it stays high.
- R9: A pulse on rd_en clears rx_done, and a pulse on rx_irq_ack clears rx_irq. Each clear acts on its own flag only.
- R10: The link is half duplex. While tx_shift_empty is 0 the receiver ignores the line, so the block's own frame never sets rx_done. A new transmission does not start while a frame is being received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count-source clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_div | input | DIV_W | Divisor n; bit time is 16 × (n + 1) cycles |
| wr_en | input | 1 | Write strobe for the transmit holding buffer |
| wr_data | input | DATA_W | Byte to transmit |
| tx_buf_empty | output | 1 | Holding buffer free |
| tx_shift_empty | output | 1 | Transmit shifter idle |
| tx_ack_level | output | 1 | Line level seen at mid-stop of the last transmitted frame |
| tx_irq | output | 1 | Transmit-complete interrupt request |
| tx_irq_ack | input | 1 | Clears tx_irq |
| rd_en | input | 1 | Read strobe, clears rx_done |
| rd_data | output | DATA_W | Last received byte |
| rx_done | output | 1 | Received byte available |
| rx_parity_err | output | 1 | Parity error on the last received byte |
| rx_irq | output | 1 | Receive-complete interrupt request |
| rx_irq_ack | input | 1 | Clears rx_irq |
| line_in | input | 1 | Resolved level of the shared line |
| tx_line_drv | output | 1 | Transmitter drive, low pulls the line low |
| err_line_drv | output | 1 | Receiver error drive, low pulls the line low |

## Verification
The checker watches several relations on every cycle. It checks that the buffer-empty flag rises only as a frame starts, and that the transmit request rises only when the shifter goes idle and holds until acknowledged. It also checks that the accept level moves only at that moment and that the error drive is never low while a transmission is under way. The exact bit timing for several divisors, the bit order and the parity values can only be shown by the bench's scenarios. The same goes for the rejection handshake between a far end and the transmitter, the error pulse placed in the stop slot, and the dropping of short start glitches. The bench covers these by acting as the card on the wired-AND line.

// File: rtl/scu_pkg.sv
package scu_pkg;

    localparam int PAR_MAX_W = 32;

    typedef enum logic [1:0] {
        TXS_IDLE,
        TXS_SEND,
        TXS_GUARD
    } tx_state_e;

    typedef enum logic [1:0] {
        RXS_IDLE,
        RXS_START,
        RXS_BITS,
        RXS_TAIL
    } rx_state_e;

    // 1 when the vector holds an odd number of ones
    function automatic logic odd_ones(input logic [PAR_MAX_W-1:0] v);
        return ^v;
    endfunction

endpackage

// File: rtl/scu_sync.sv
module scu_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) stage_q <= '1;
        else     stage_q <= {stage_q[STAGES-2:0], d};
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/scu_tx.sv
module scu_tx
    import scu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  bit_per,
    input  logic [CNT_W-1:0]  bit_half,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rx_busy,
    input  logic              line_s,
    input  logic              irq_ack,
    output logic              line_drv,
    output logic              buf_empty,
    output logic              shift_empty,
    output logic              ack_level,
    output logic              irq
);
    localparam int FRAME_W  = DATA_W + 2;          // data, parity, stop
    localparam int STOP_IDX = DATA_W + 2;          // bits before stop: start, data, parity
    localparam int IDX_W    = $clog2(DATA_W + 3);

    tx_state_e          state;
    logic [DATA_W-1:0]  hold;
    logic               hold_vld;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   cnt;
    logic [IDX_W-1:0]   idx;
    logic               bit_end;
    logic               stop_mid;

    assign bit_end  = (cnt == bit_per - 1'b1);
    assign stop_mid = (idx == IDX_W'(STOP_IDX)) && (cnt == bit_half - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= TXS_IDLE;
            hold        <= '0;
            hold_vld    <= 1'b0;
            frame       <= '1;
            cnt         <= '0;
            idx         <= '0;
            line_drv    <= 1'b1;
            buf_empty   <= 1'b1;
            shift_empty <= 1'b1;
            ack_level   <= 1'b1;
            irq         <= 1'b0;
        end else begin
            if (irq_ack) irq <= 1'b0;

            unique case (state)
                TXS_IDLE: begin
                    if (hold_vld && !rx_busy) begin
                        state       <= TXS_SEND;
                        frame       <= {1'b1, odd_ones(PAR_MAX_W'(hold)), hold};
                        line_drv    <= 1'b0;
                        cnt         <= '0;
                        idx         <= '0;
                        shift_empty <= 1'b0;
                        hold_vld    <= 1'b0;
                        buf_empty   <= 1'b1;
                    end
                end
                TXS_SEND: begin
                    if (stop_mid) begin
                        ack_level   <= line_s;
                        irq         <= 1'b1;
                        shift_empty <= 1'b1;
                        state       <= TXS_GUARD;
                        cnt         <= cnt + 1'b1;
                    end else if (bit_end) begin
                        cnt      <= '0;
                        line_drv <= frame[0];
                        frame    <= {1'b1, frame[FRAME_W-1:1]};
                        idx      <= idx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                TXS_GUARD: begin
                    // finish the stop bit before another frame may start
                    if (bit_end) state <= TXS_IDLE;
                    else         cnt   <= cnt + 1'b1;
                end
                default: state <= TXS_IDLE;
            endcase

            // a write lands after any transfer in the same cycle
            if (wr_en) begin
                hold      <= wr_data;
                hold_vld  <= 1'b1;
                buf_empty <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/scu_rx.sv
module scu_rx
    import scu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  bit_per,
    input  logic [CNT_W-1:0]  bit_half,
    input  logic              line_s,
    input  logic              enable,
    input  logic              rd_en,
    input  logic              irq_ack,
    output logic              busy,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              perr,
    output logic              irq,
    output logic              err_drv
);
    localparam int IDX_W = $clog2(DATA_W + 1);

    rx_state_e        state;
    logic             line_prev;
    logic [DATA_W:0]  shift;      // parity in the top bit once full
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] idx;
    logic             bad_par;

    assign busy    = (state != RXS_IDLE);
    assign bad_par = odd_ones(PAR_MAX_W'(shift));

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= RXS_IDLE;
            line_prev <= 1'b1;
            shift     <= '0;
            cnt       <= '0;
            idx       <= '0;
            rd_data   <= '0;
            done      <= 1'b0;
            perr      <= 1'b0;
            irq       <= 1'b0;
            err_drv   <= 1'b1;
        end else begin
            line_prev <= line_s;
            if (rd_en)   done <= 1'b0;
            if (irq_ack) irq  <= 1'b0;

            unique case (state)
                RXS_IDLE: begin
                    if (enable && line_prev && !line_s) begin
                        state <= RXS_START;
                        cnt   <= '0;
                    end
                end
                RXS_START: begin
                    if (cnt == bit_half - 1'b1) begin
                        cnt <= '0;
                        idx <= '0;
                        state <= line_s ? RXS_IDLE : RXS_BITS;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RXS_BITS: begin
                    if (cnt == bit_per - 1'b1) begin
                        shift <= {line_s, shift[DATA_W:1]};
                        cnt   <= '0;
                        if (idx == IDX_W'(DATA_W)) state <= RXS_TAIL;
                        else                       idx   <= idx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RXS_TAIL: begin
                    // cnt runs from the parity sample to the end of the stop slot
                    cnt <= cnt + 1'b1;
                    if (cnt == bit_half - 1'b1 && bad_par) err_drv <= 1'b0;
                    if (cnt == bit_per - 1'b1) begin
                        done    <= 1'b1;
                        irq     <= 1'b1;
                        rd_data <= shift[DATA_W-1:0];
                        perr    <= bad_par;
                    end
                    if (cnt == bit_per + bit_half - 1'b1) begin
                        err_drv <= 1'b1;
                        state   <= RXS_IDLE;
                    end
                end
                default: state <= RXS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/smartcard_uart.sv
module smartcard_uart
    import scu_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tx_buf_empty,
    output logic              tx_shift_empty,
    output logic              tx_ack_level,
    output logic              tx_irq,
    input  logic              tx_irq_ack,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_done,
    output logic              rx_parity_err,
    output logic              rx_irq,
    input  logic              rx_irq_ack,
    input  logic              line_in,
    output logic              tx_line_drv,
    output logic              err_line_drv
);
    // 16*(n+1) plus half a bit must fit: 24 * 2^DIV_W < 2^(DIV_W+5)
    localparam int CNT_W = DIV_W + 5;

    logic [CNT_W-1:0] div_ext;
    logic [CNT_W-1:0] bit_per;
    logic [CNT_W-1:0] bit_half;
    logic             line_s;
    logic             rx_busy;

    assign div_ext  = CNT_W'(baud_div) + CNT_W'(1);
    assign bit_per  = div_ext << 4;
    assign bit_half = div_ext << 3;

    scu_sync #(.STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (line_in),
        .q   (line_s)
    );

    scu_tx #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_tx (
        .clk         (clk),
        .rst         (rst),
        .bit_per     (bit_per),
        .bit_half    (bit_half),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rx_busy     (rx_busy),
        .line_s      (line_s),
        .irq_ack     (tx_irq_ack),
        .line_drv    (tx_line_drv),
        .buf_empty   (tx_buf_empty),
        .shift_empty (tx_shift_empty),
        .ack_level   (tx_ack_level),
        .irq         (tx_irq)
    );

    scu_rx #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .bit_per  (bit_per),
        .bit_half (bit_half),
        .line_s   (line_s),
        .enable   (tx_shift_empty),
        .rd_en    (rd_en),
        .irq_ack  (rx_irq_ack),
        .busy     (rx_busy),
        .rd_data  (rd_data),
        .done     (rx_done),
        .perr     (rx_parity_err),
        .irq      (rx_irq),
        .err_drv  (err_line_drv)
    );
endmodule

// File: rtl/scu_checker.sv
module scu_checker (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic tx_buf_empty,
    input logic tx_shift_empty,
    input logic tx_line_drv,
    input logic tx_irq,
    input logic tx_irq_ack,
    input logic tx_ack_level,
    input logic err_line_drv,
    input logic rx_done,
    input logic rx_irq
);
    assert_wr_clears_empty_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !tx_buf_empty);

    assert_empty_with_start_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_buf_empty) |-> ($fell(tx_shift_empty) && !tx_line_drv));

    assert_irq_at_done_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_irq) |-> $rose(tx_shift_empty));

    assert_irq_held_R4: assert property (@(posedge clk) disable iff (rst)
        (tx_irq && !tx_irq_ack) |=> tx_irq);

    assert_ack_moves_at_done_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(tx_ack_level) |-> $rose(tx_shift_empty));

    assert_rx_irq_with_done_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_done) |-> rx_irq);

    assert_no_err_while_sending_R10: assert property (@(posedge clk) disable iff (rst)
        !err_line_drv |-> (tx_shift_empty && tx_line_drv));
endmodule

bind smartcard_uart scu_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .wr_en          (wr_en),
    .tx_buf_empty   (tx_buf_empty),
    .tx_shift_empty (tx_shift_empty),
    .tx_line_drv    (tx_line_drv),
    .tx_irq         (tx_irq),
    .tx_irq_ack     (tx_irq_ack),
    .tx_ack_level   (tx_ack_level),
    .err_line_drv   (err_line_drv),
    .rx_done        (rx_done),
    .rx_irq         (rx_irq)
);

// File: tb/smartcard_uart_test.sv
module smartcard_uart_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] baud_div = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       tx_irq_ack = 1'b0;
    logic       rd_en = 1'b0;
    logic       rx_irq_ack = 1'b0;
    logic       tb_drv = 1'b1;
    logic       tx_buf_empty, tx_shift_empty, tx_ack_level, tx_irq;
    logic [7:0] rd_data;
    logic       rx_done, rx_parity_err, rx_irq;
    logic       tx_line_drv, err_line_drv;
    logic       line;

    int n_checks = 0;
    int n_fail   = 0;
    int per_c    = 16;
    int half_c   = 8;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    assign line = tx_line_drv & err_line_drv & tb_drv;

    smartcard_uart uut (
        .clk            (clk),
        .rst            (rst),
        .baud_div       (baud_div),
        .wr_en          (wr_en),
        .wr_data        (wr_data),
        .tx_buf_empty   (tx_buf_empty),
        .tx_shift_empty (tx_shift_empty),
        .tx_ack_level   (tx_ack_level),
        .tx_irq         (tx_irq),
        .tx_irq_ack     (tx_irq_ack),
        .rd_en          (rd_en),
        .rd_data        (rd_data),
        .rx_done        (rx_done),
        .rx_parity_err  (rx_parity_err),
        .rx_irq         (rx_irq),
        .rx_irq_ack     (rx_irq_ack),
        .line_in        (line),
        .tx_line_drv    (tx_line_drv),
        .err_line_drv   (err_line_drv)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_div(input int d);
        baud_div = 8'(d);
        per_c    = 16 * (d + 1);
        half_c   = 8 * (d + 1);
        wait_cycles(4);
    endtask

    task automatic wait_line_low(output int waited);
        waited = 0;
        while (line !== 1'b0 && waited < 200) begin
            @(negedge clk);
            waited++;
        end
    endtask

    // R2: length of the start bit equals one bit period
    task automatic measure_period();
        int w;
        int len;
        @(negedge clk); wr_en = 1'b1; wr_data = 8'hFF;
        @(negedge clk); wr_en = 1'b0;
        wait_line_low(w);
        len = 0;
        while (line === 1'b0 && len < 5000) begin
            @(negedge clk);
            len++;
        end
        check("R2 bit period", len, per_c);
        w = 0;
        while (tx_shift_empty !== 1'b1 && w < 5000) begin @(negedge clk); w++; end
        wait_cycles(per_c);
        tx_irq_ack = 1'b1; @(negedge clk); tx_irq_ack = 1'b0;
    endtask

    // bench acts as the card receiving one frame from the block
    task automatic tx_frame(input logic [7:0] data, input bit reject);
        int w;
        logic [7:0] got;
        logic par;
        logic st;
        @(negedge clk); wr_en = 1'b1; wr_data = data;
        @(negedge clk); wr_en = 1'b0;
        check("R3 buffer busy after write", int'(tx_buf_empty), 0);
        wait_line_low(w);
        check("R3 buffer empty at start bit", int'(tx_buf_empty), 1);
        check("R4 shifter busy at start bit", int'(tx_shift_empty), 0);
        wait_cycles(half_c);
        st = line;
        for (int i = 0; i < 8; i++) begin
            wait_cycles(per_c);
            got[i] = line;
        end
        wait_cycles(per_c);
        par = line;
        check("R2 start bit low", int'(st), 0);
        check("R2 data bits lsb first", int'(got), int'(data));
        check("R2 even parity bit", int'(par), int'(^data));
        wait_cycles(half_c);
        if (reject) tb_drv = 1'b0;
        wait_cycles(half_c);
        if (!reject) check("R2 stop bit high", int'(line), 1);
        wait_cycles(half_c);
        tb_drv = 1'b1;
        wait_cycles(4);
        check("R4 shifter idle after stop", int'(tx_shift_empty), 1);
        check("R4 transmit request raised", int'(tx_irq), 1);
        check("R5 accept level", int'(tx_ack_level), reject ? 0 : 1);
        check("R10 own frame not received", int'(rx_done), 0);
        tx_irq_ack = 1'b1; @(negedge clk); tx_irq_ack = 1'b0;
        check("R4 request cleared by ack", int'(tx_irq), 0);
    endtask

    // bench acts as the card sending one frame to the block
    task automatic rx_frame(input logic [7:0] data, input bit bad);
        tb_drv = 1'b0;
        wait_cycles(per_c);
        for (int i = 0; i < 8; i++) begin
            tb_drv = data[i];
            wait_cycles(per_c);
        end
        tb_drv = (^data) ^ bad;
        wait_cycles(per_c);
        tb_drv = 1'b1;
        wait_cycles(half_c);
        check("R8 line in stop slot", int'(line), bad ? 0 : 1);
        wait_cycles(half_c + 8);
        check("R8 error drive released", int'(line), 1);
        check("R7 receive done", int'(rx_done), 1);
        check("R7 receive request", int'(rx_irq), 1);
        check("R7 received byte", int'(rd_data), int'(data));
        check("R7 parity error flag", int'(rx_parity_err), bad ? 1 : 0);
        check("R10 transmitter stays idle", int'(tx_shift_empty), 1);
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
        check("R9 read clears done", int'(rx_done), 0);
        check("R9 read keeps request", int'(rx_irq), 1);
        rx_irq_ack = 1'b1; @(negedge clk); rx_irq_ack = 1'b0;
        check("R9 ack clears request", int'(rx_irq), 0);
    endtask

    task automatic glitch(input int len);
        tb_drv = 1'b0;
        wait_cycles(len);
        tb_drv = 1'b1;
        wait_cycles(2 * per_c);
        check("R6 short pulse ignored", int'(rx_done), 0);
        check("R6 no error drive after pulse", int'(err_line_drv), 1);
    endtask

    initial begin
        wait_cycles(190000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        wait_cycles(5);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 tx drive", int'(tx_line_drv), 1);
        check("R1 err drive", int'(err_line_drv), 1);
        check("R1 buffer empty", int'(tx_buf_empty), 1);
        check("R1 shifter empty", int'(tx_shift_empty), 1);
        check("R1 accept level", int'(tx_ack_level), 1);
        check("R1 flags", int'({rx_done, rx_parity_err, tx_irq, rx_irq}), 0);

        set_div(0);
        measure_period();
        for (int b = 0; b < 256; b += 3) tx_frame(8'(b), 1'b0);
        for (int b = 0; b < 256; b++) rx_frame(8'(b), (b % 16) == 5);

        set_div(1);
        measure_period();
        for (int k = 0; k < 4; k++) tx_frame(8'(8'hA5 + 8'(k * 37)), (k % 2) == 0);
        glitch(3);
        rx_frame(8'h3C, 1'b0);
        glitch(10);
        for (int k = 0; k < 4; k++) rx_frame(8'(8'h81 + 8'(k * 19)), (k % 2) == 1);

        set_div(3);
        measure_period();
        tx_frame(8'h96, 1'b1);
        tx_frame(8'h01, 1'b0);
        rx_frame(8'h7E, 1'b1);
        rx_frame(8'hC3, 1'b0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule